// File: doc/BRIEF.md
# Memory Type Caching Translation Buffer

This block is a small fully associative translation buffer that also decides the memory type of each page it holds. A set of programmable physical range registers describes the memory type of address ranges. Each register has a base, a mask, a type and a valid flag. A separate default-type register applies wherever no range matches.

The range registers are not consulted on ordinary accesses. They are evaluated only when a page translation is loaded, or filled, into the buffer. At that moment the page frame is compared against every valid range. The range outcome is then merged with the type bits carried by the page entry, and the merged result is stored in the buffer line. Every later access to the page reads the memory type straight from its matching line.

A lookup that misses raises a fill request and stalls, meaning the requester holds the lookup, until fill data arrives. Because range results are cached per line, any configuration write flushes every line, including lines marked global. This keeps every line consistent with the ranges that are currently programmed.

Top module: `mtype_tlb`

## Requirements
- R1: After reset every line is invalid: any lookup misses, so `lk_hit`=0 and `fill_req`=1 while `lk_valid`=1. Both outputs are 0 whenever `lk_valid`=0.
- R2: While `lk_valid`=1 and no valid line holds `lk_vpn`, the block drives `lk_hit`=0 and `fill_req`=1. `lk_hit` and `fill_req` are never 1 together.
- R3: When `fill_valid`=1 is sampled at a clock edge while a miss is pending, the pending page is written into a line. From the next cycle the same `lk_vpn` hits and returns the fill's frame on `lk_frame` and its global flag on `lk_global`.
- R4: Range i matches a frame F when its valid flag is 1 and (F AND mask) equals (base AND mask). A range whose valid flag is 0 never matches.
- R5: Type codes are UC=0, WC=1, WT=2, WP=3 and WB=4, with restrictiveness falling in that order. Codes 5 to 7 are read as UC. When several ranges match, the range result is the most restrictive of their types, so UC overrides everything and WT with WB gives WT.
- R6: When no range matches, the range result is the default-type register. Configuration index NRANGE writes the default type. Indices 0 to NRANGE-1 write range registers. After reset the default is UC and every range is invalid.
- R7: The stored type is the more restrictive of the range result and the fill's page type (`fill_ptype`, with codes 5 to 7 read as UC). On a hit, `lk_type` returns this stored type.
- R8: Any configuration write (`cfg_we`=1) invalidates every line, including lines filled with the global flag set. In the cycle after the write, every lookup misses.
- R9: A lookup in the same cycle as a configuration write misses, with `lk_hit`=0 and `fill_req`=1, even when the page was held before the write.
- R10: A fill that coincides with a configuration write is dropped, and the page still misses afterwards.
- R11: Lines are replaced in fill order starting from line 0 after reset or a flush. Once NENTRY pages are held, the next fill evicts the oldest one and keeps the other NENTRY-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe; also flushes all lines |
| cfg_idx | input | $clog2(NRANGE+1) | Selects range register 0..NRANGE-1, or the default type at NRANGE |
| cfg_base | input | FRAME_W | Range base frame |
| cfg_mask | input | FRAME_W | Range frame mask |
| cfg_type | input | 3 | Range or default memory type code |
| cfg_valid | input | 1 | Range valid flag |
| lk_valid | input | 1 | Lookup present; held until it hits |
| lk_vpn | input | VPN_W | Virtual page number being looked up |
| lk_hit | output | 1 | Lookup hit this cycle |
| lk_frame | output | FRAME_W | Physical frame of the hit line |
| lk_type | output | 3 | Cached memory type of the hit line |
| lk_global | output | 1 | Global flag of the hit line |
| fill_req | output | 1 | Miss pending, so the lookup stalls and requests a fill |
| fill_valid | input | 1 | Fill data present for the pending miss |
| fill_frame | input | FRAME_W | Physical frame of the filled page |
| fill_ptype | input | 3 | Memory type bits from the page entry |
| fill_global | input | 1 | Global flag from the page entry |

## Verification
The type merge is swept over every pair of range types and all eight page-type codes. Each combination is tried with four frames: one inside both overlapping ranges, one inside only the first range, one inside only the second, and one outside both. These four frames separate the overlap rule from the single-range path and from the default path. The default type changes with each range pair, so a default path that used a range type by mistake would be caught. Separate sequences cover the other rules:
- an invalidated range, which shows that the valid flag gates matching;
- a flush that removes a global line;
- a write and a lookup in the same cycle;
- a fill that collides with a write;
- one fill past capacity, which shows which line is evicted.

// File: rtl/mtype_pkg.sv
package mtype_pkg;

   // Type codes ordered from most to least restrictive.
   localparam logic [2:0] MT_UC = 3'd0;
   localparam logic [2:0] MT_WC = 3'd1;
   localparam logic [2:0] MT_WT = 3'd2;
   localparam logic [2:0] MT_WP = 3'd3;
   localparam logic [2:0] MT_WB = 3'd4;

   // Codes outside the defined set are treated as uncacheable.
   function automatic logic [2:0] mt_sanitize(input logic [2:0] code);
      return (code > MT_WB) ? MT_UC : code;
   endfunction

   // The smaller code is the more restrictive type.
   function automatic logic [2:0] mt_stricter(input logic [2:0] a, input logic [2:0] b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/mtype_range_resolve.sv
module mtype_range_resolve
   import mtype_pkg::*;
#(
   parameter int NRANGE  = 4,
   parameter int FRAME_W = 20
) (
   input  logic [FRAME_W-1:0]              frame,
   input  logic [NRANGE-1:0][FRAME_W-1:0]  rng_base,
   input  logic [NRANGE-1:0][FRAME_W-1:0]  rng_mask,
   input  logic [NRANGE-1:0][2:0]          rng_type,
   input  logic [NRANGE-1:0]               rng_vld,
   input  logic [2:0]                      dflt_type,
   output logic [2:0]                      res_type
);

   logic [NRANGE-1:0] rng_hit;

   for (genvar r = 0; r < NRANGE; r++) begin : g_cmp
      assign rng_hit[r] = rng_vld[r] &&
                          ((frame & rng_mask[r]) == (rng_base[r] & rng_mask[r]));
   end

   always_comb begin
      logic       any_hit;
      logic [2:0] acc;
      any_hit = 1'b0;
      acc     = MT_WB;
      for (int r = 0; r < NRANGE; r++) begin
         if (rng_hit[r]) begin
            any_hit = 1'b1;
            acc     = mt_stricter(acc, mt_sanitize(rng_type[r]));
         end
      end
      res_type = any_hit ? acc : mt_sanitize(dflt_type);
   end

endmodule

// File: rtl/mtype_merge.sv
module mtype_merge
   import mtype_pkg::*;
(
   input  logic [2:0] range_type,
   input  logic [2:0] page_type,
   output logic [2:0] merged_type
);

   logic [2:0] page_clean;

   assign page_clean  = mt_sanitize(page_type);
   assign merged_type = mt_stricter(range_type, page_clean);

endmodule

// File: rtl/mtype_tlb_array.sv
module mtype_tlb_array #(
   parameter int NENTRY     = 8,
   parameter int VPN_W      = 20,
   parameter int FRAME_W    = 20,
   parameter bit ONEHOT_SEL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_frame,
   output logic [2:0]         hit_type,
   output logic               hit_global,
   input  logic               wr_en,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [2:0]         wr_type,
   input  logic               wr_global
);

   localparam int PTR_W = $clog2(NENTRY);
   localparam int DAT_W = FRAME_W + 3 + 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NENTRY - 1);

   logic [NENTRY-1:0]              ent_vld;
   logic [NENTRY-1:0][VPN_W-1:0]   ent_tag;
   logic [NENTRY-1:0][DAT_W-1:0]   ent_dat;
   logic [NENTRY-1:0]              hit_vec;
   logic [PTR_W-1:0]               ptr;
   logic [DAT_W-1:0]               sel_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= '0;
         ptr     <= '0;
      end else if (flush) begin
         ent_vld <= '0;
         ptr     <= '0;
      end else if (wr_en) begin
         ent_vld[ptr] <= 1'b1;
         ptr          <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         ent_tag[ptr] <= wr_vpn;
         ent_dat[ptr] <= {wr_frame, wr_type, wr_global};
      end
   end

   for (genvar e = 0; e < NENTRY; e++) begin : g_match
      assign hit_vec[e] = ent_vld[e] && (ent_tag[e] == lk_vpn);
   end

   if (ONEHOT_SEL) begin : g_andor
      always_comb begin
         sel_dat = '0;
         for (int e = 0; e < NENTRY; e++)
            sel_dat = sel_dat | (ent_dat[e] & {DAT_W{hit_vec[e]}});
      end
   end else begin : g_prio
      always_comb begin
         sel_dat = '0;
         for (int e = NENTRY - 1; e >= 0; e--)
            if (hit_vec[e]) sel_dat = ent_dat[e];
      end
   end

   assign hit        = |hit_vec;
   assign hit_frame  = sel_dat[DAT_W-1 -: FRAME_W];
   assign hit_type   = sel_dat[3:1];
   assign hit_global = sel_dat[0];

endmodule

// File: rtl/mtype_tlb.sv
module mtype_tlb
   import mtype_pkg::*;
#(
   parameter int NENTRY     = 8,
   parameter int NRANGE     = 4,
   parameter int VPN_W      = 20,
   parameter int FRAME_W    = 20,
   parameter bit ONEHOT_SEL = 1'b1,
   localparam int IDX_W     = $clog2(NRANGE + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [FRAME_W-1:0] cfg_base,
   input  logic [FRAME_W-1:0] cfg_mask,
   input  logic [2:0]         cfg_type,
   input  logic               cfg_valid,
   input  logic               lk_valid,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic [2:0]         lk_type,
   output logic               lk_global,
   output logic               fill_req,
   input  logic               fill_valid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic [2:0]         fill_ptype,
   input  logic               fill_global
);

   if (NENTRY < 2)  begin : g_bad_nentry  $error("NENTRY must be at least 2");  end
   if (NRANGE < 1)  begin : g_bad_nrange  $error("NRANGE must be at least 1");  end
   if (FRAME_W < 1) begin : g_bad_frame   $error("FRAME_W must be at least 1"); end
   if (VPN_W < 1)   begin : g_bad_vpn     $error("VPN_W must be at least 1");   end

   logic [NRANGE-1:0][FRAME_W-1:0] rng_base;
   logic [NRANGE-1:0][FRAME_W-1:0] rng_mask;
   logic [NRANGE-1:0][2:0]         rng_type;
   logic [NRANGE-1:0]              rng_vld;
   logic [2:0]                     dflt_type;

   for (genvar r = 0; r < NRANGE; r++) begin : g_rng
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rng_base[r] <= '0;
            rng_mask[r] <= '0;
            rng_type[r] <= MT_UC;
            rng_vld[r]  <= 1'b0;
         end else if (cfg_we && cfg_idx == IDX_W'(r)) begin
            rng_base[r] <= cfg_base;
            rng_mask[r] <= cfg_mask;
            rng_type[r] <= cfg_type;
            rng_vld[r]  <= cfg_valid;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dflt_type <= MT_UC;
      else if (cfg_we && cfg_idx == IDX_W'(NRANGE))
         dflt_type <= cfg_type;
   end

   logic [2:0] range_res;
   logic [2:0] fill_type;

   mtype_range_resolve #(.NRANGE(NRANGE), .FRAME_W(FRAME_W)) u_resolve (
      .frame     (fill_frame),
      .rng_base  (rng_base),
      .rng_mask  (rng_mask),
      .rng_type  (rng_type),
      .rng_vld   (rng_vld),
      .dflt_type (dflt_type),
      .res_type  (range_res)
   );

   mtype_merge u_merge (
      .range_type  (range_res),
      .page_type   (fill_ptype),
      .merged_type (fill_type)
   );

   logic               raw_hit;
   logic [FRAME_W-1:0] raw_frame;
   logic [2:0]         raw_type;
   logic               raw_global;
   logic               wr_en;

   // A configuration write flushes at the edge, so a lookup in that cycle
   // is served as if the flush had already happened.
   assign lk_hit   = lk_valid && raw_hit && !cfg_we;
   assign fill_req = lk_valid && !lk_hit;
   assign wr_en    = fill_req && fill_valid && !cfg_we;

   mtype_tlb_array #(
      .NENTRY(NENTRY), .VPN_W(VPN_W), .FRAME_W(FRAME_W), .ONEHOT_SEL(ONEHOT_SEL)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (cfg_we),
      .lk_vpn     (lk_vpn),
      .hit        (raw_hit),
      .hit_frame  (raw_frame),
      .hit_type   (raw_type),
      .hit_global (raw_global),
      .wr_en      (wr_en),
      .wr_vpn     (lk_vpn),
      .wr_frame   (fill_frame),
      .wr_type    (fill_type),
      .wr_global  (fill_global)
   );

   assign lk_frame  = lk_hit ? raw_frame  : '0;
   assign lk_type   = lk_hit ? raw_type   : MT_UC;
   assign lk_global = lk_hit ? raw_global : 1'b0;

endmodule

// File: rtl/mtype_tlb_chk.sv
module mtype_tlb_chk #(
   parameter int VPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             lk_valid,
   input logic [VPN_W-1:0] lk_vpn,
   input logic             lk_hit,
   input logic [2:0]       lk_type,
   input logic             fill_req,
   input logic             fill_valid
);

   // R1: no lookup, no hit and no request
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !fill_req));

   // R2: hit and request exclude each other
   a_r2_hit_xor_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && fill_req));

   // R3: an accepted fill makes the same page hit next cycle
   a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && fill_valid && !cfg_we) |=>
      (!lk_valid || lk_vpn != $past(lk_vpn) || cfg_we || lk_hit));

   // R7: a cached type is always one of the defined codes
   a_r7_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_type <= 3'd4));

   // R8: every line is gone the cycle after a configuration write
   a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !lk_hit);

   // R9: a lookup beside a configuration write misses
   a_r9_same_cycle_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && lk_valid) |-> (!lk_hit && fill_req));

endmodule

bind mtype_tlb mtype_tlb_chk #(.VPN_W(VPN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .lk_valid   (lk_valid),
   .lk_vpn     (lk_vpn),
   .lk_hit     (lk_hit),
   .lk_type    (lk_type),
   .fill_req   (fill_req),
   .fill_valid (fill_valid)
);

// File: tb/mtype_tlb_test.sv
`timescale 1ns/1ps
module mtype_tlb_test;

   localparam int NE = 4;
   localparam int NR = 2;
   localparam int VW = 8;
   localparam int FW = 20;
   localparam int IW = $clog2(NR + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [FW-1:0] cfg_base = '0, cfg_mask = '0;
   logic [2:0]    cfg_type = '0;
   logic          cfg_valid = 1'b0;
   logic          lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_hit, lk_global, fill_req;
   logic [FW-1:0] lk_frame;
   logic [2:0]    lk_type;
   logic          fill_valid = 1'b0;
   logic [FW-1:0] fill_frame = '0;
   logic [2:0]    fill_ptype = '0;
   logic          fill_global = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mtype_tlb #(.NENTRY(NE), .NRANGE(NR), .VPN_W(VW), .FRAME_W(FW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
      .cfg_type(cfg_type), .cfg_valid(cfg_valid),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame),
      .lk_type(lk_type), .lk_global(lk_global), .fill_req(fill_req),
      .fill_valid(fill_valid), .fill_frame(fill_frame), .fill_ptype(fill_ptype),
      .fill_global(fill_global)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int idx, input int base, input int mask,
                            input int typ, input bit vld);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_base = FW'(base); cfg_mask = FW'(mask);
      cfg_type = 3'(typ); cfg_valid = vld;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Drive a lookup for vpn; leave it applied and sample after settling.
   task automatic probe(input int vpn);
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = VW'(vpn);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   // Miss, supply a fill, then leave the lookup applied in the hit cycle.
   task automatic do_fill(input int vpn, input int frame, input int pt, input bit g);
      probe(vpn);
      fill_valid = 1'b1; fill_frame = FW'(frame); fill_ptype = 3'(pt); fill_global = g;
      @(negedge clk);
      fill_valid = 1'b0;
      #1;
   endtask

   function automatic int strict(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int clean(input int c);
      return (c > 4) ? 0 : c;
   endfunction

   // Ranges used in the sweep: r0 covers frames 0x1xxxx, r1 covers bits 15:12 == 1.
   function automatic int expect_type(input int t0, input int t1, input int dflt,
                                      input int frame, input int pt);
      bit m0, m1;
      int rr;
      m0 = ((frame & 32'hF0000) == 32'h10000);
      m1 = ((frame & 32'h0F000) == 32'h01000);
      if (m0 && m1)  rr = strict(t0, t1);
      else if (m0)   rr = t0;
      else if (m1)   rr = t1;
      else           rr = dflt;
      return strict(rr, clean(pt));
   endfunction

   initial begin
      int frames[4];
      frames = '{32'h11ABC, 32'h12ABC, 32'h21ABC, 32'h32ABC};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      probe(8'h05);
      check("R1 hit after reset", lk_hit, 0);
      check("R1 fill_req after reset", fill_req, 1);
      idle(); #1;
      check("R1 fill_req idle", fill_req, 0);
      check("R1 hit idle", lk_hit, 0);

      // R2 and R3: miss, fill, then hit with frame and global flag (default UC)
      probe(8'h07);
      check("R2 miss hit", lk_hit, 0);
      check("R2 miss req", fill_req, 1);
      fill_valid = 1'b1; fill_frame = 20'h5A5A5; fill_ptype = 3'd4; fill_global = 1'b1;
      @(negedge clk); fill_valid = 1'b0; #1;
      check("R3 hit after fill", lk_hit, 1);
      check("R3 req after fill", fill_req, 0);
      check("R3 frame", lk_frame, 32'h5A5A5);
      check("R3 global", lk_global, 1);
      check("R6 reset default UC", lk_type, 0);

      // R8: a configuration write removes a global line
      idle();
      cfg_write(NR, 0, 0, 4, 1'b0);
      probe(8'h07);
      check("R8 global line flushed", lk_hit, 0);
      idle();

      // R5 R6 R7 sweep over range type pairs, page types and frame classes
      for (int t0 = 0; t0 < 5; t0++) begin
         for (int t1 = 0; t1 < 5; t1++) begin
            int dflt;
            dflt = (t0 + t1) % 5;
            cfg_write(0, 32'h10000, 32'hF0000, t0, 1'b1);
            cfg_write(1, 32'h01000, 32'h0F000, t1, 1'b1);
            cfg_write(NR, 0, 0, dflt, 1'b0);
            for (int pt = 0; pt < 8; pt++) begin
               for (int c = 0; c < 4; c++) begin
                  do_fill(pt * 4 + c, frames[c], pt, 1'b0);
                  check($sformatf("R7 R5 R6 type t0=%0d t1=%0d pt=%0d cls=%0d", t0, t1, pt, c),
                        lk_type, expect_type(t0, t1, dflt, frames[c], pt));
               end
            end
            idle();
         end
      end

      // R4: invalid range never matches, so the default applies
      cfg_write(0, 32'h10000, 32'hF0000, 0, 1'b1);
      cfg_write(1, 32'h01000, 32'h0F000, 0, 1'b0);
      cfg_write(NR, 0, 0, 2, 1'b0);
      do_fill(8'h40, 32'h21ABC, 4, 1'b0);
      check("R4 invalid range ignored", lk_type, 2);
      do_fill(8'h41, 32'h12ABC, 4, 1'b0);
      check("R4 valid range matches", lk_type, 0);

      // R9: same-cycle write and lookup
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(NR); cfg_type = 3'd4; lk_vpn = 8'h41; lk_valid = 1'b1;
      #1;
      check("R9 same cycle hit", lk_hit, 0);
      check("R9 same cycle req", fill_req, 1);
      @(negedge clk);
      cfg_we = 1'b0; #1;
      check("R9 still miss after write", lk_hit, 0);

      // R10: fill colliding with a configuration write is dropped
      @(negedge clk);
      lk_vpn = 8'h42; fill_valid = 1'b1; fill_frame = 20'h00123; fill_ptype = 3'd4;
      cfg_we = 1'b1; cfg_idx = IW'(NR); cfg_type = 3'd4;
      @(negedge clk);
      cfg_we = 1'b0; fill_valid = 1'b0; #1;
      check("R10 colliding fill dropped", lk_hit, 0);
      idle();

      // R11: capacity and oldest-first eviction after a flush
      cfg_write(NR, 0, 0, 4, 1'b0);
      for (int i = 0; i < NE; i++) do_fill(8'hA0 + i, 32'h00100 + i, 4, 1'b0);
      for (int i = 0; i < NE; i++) begin
         probe(8'hA0 + i);
         check($sformatf("R11 held page %0d", i), lk_hit, 1);
         check($sformatf("R11 held frame %0d", i), lk_frame, 32'h00100 + i);
      end
      do_fill(8'hA0 + NE, 32'h00200, 4, 1'b0);
      probe(8'hA0);
      check("R11 oldest evicted", lk_hit, 0);
      for (int i = 1; i <= NE; i++) begin
         probe(8'hA0 + i);
         check($sformatf("R11 survivor %0d", i), lk_hit, 1);
      end
      idle();

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule